// File: doc/BRIEF.md
# Shared Test Access Port Controller

This block is the top-level boundary-scan test access port of a chip. It runs the standard sixteen-state TAP state machine on TCK and TMS, holds a 5-bit instruction register, and contains the device-identification and bypass data registers. For boundary scan it drives capture, shift and update strobes to the external scan cells, along with an external-test drive request and a functional reset request.

A band of opcodes hands the whole port to one of six auxiliary TAP controllers. While a grant is held, TMS and TDI are forwarded to the selected auxiliary and its TDO is routed to the pin. A lockstep opcode selects both core auxiliaries at once and broadcasts TDI to them. An enable input gates the whole controller. While it is low, the machine is held in Test-Logic-Reset.

The state machine has these states and transitions, with the TMS value that causes each one:

| State | TMS=0 | TMS=1 |
|---|---|---|
| TAP_RESET | TAP_IDLE | TAP_RESET |
| TAP_IDLE | TAP_IDLE | TAP_SEL_DR |
| TAP_SEL_DR | TAP_CAP_DR | TAP_SEL_IR |
| TAP_CAP_DR | TAP_SH_DR | TAP_EX1_DR |
| TAP_SH_DR | TAP_SH_DR | TAP_EX1_DR |
| TAP_EX1_DR | TAP_PAU_DR | TAP_UPD_DR |
| TAP_PAU_DR | TAP_PAU_DR | TAP_EX2_DR |
| TAP_EX2_DR | TAP_SH_DR | TAP_UPD_DR |
| TAP_UPD_DR | TAP_IDLE | TAP_SEL_DR |
| TAP_SEL_IR | TAP_CAP_IR | TAP_RESET |
| TAP_CAP_IR | TAP_SH_IR | TAP_EX1_IR |
| TAP_SH_IR | TAP_SH_IR | TAP_EX1_IR |
| TAP_EX1_IR | TAP_PAU_IR | TAP_UPD_IR |
| TAP_PAU_IR | TAP_PAU_IR | TAP_EX2_IR |
| TAP_EX2_IR | TAP_SH_IR | TAP_UPD_IR |
| TAP_UPD_IR | TAP_IDLE | TAP_SEL_DR |

Top module: `tsh_tap_share`

## Requirements
- R1: While `en` is 0, the controller stays in TAP_RESET and ignores TMS. In that state `tdo_oe`, `aux_sel` and `func_reset_req` are all 0. When `en` returns to 1, the active instruction is the identification opcode 00001.
- R2: Entering TAP_RESET through TMS (five rising edges with TMS=1) restores opcode 00001 and releases any auxiliary grant.
- R3: In TAP_CAP_IR the instruction shifter loads 00001, and it shifts out LSB first. A shifted opcode becomes active only on the rising edge that leaves TAP_UPD_IR.
- R4: Opcode 00001 selects a 32-bit identification register. It loads ID_VALUE (LSB 1) in TAP_CAP_DR and shifts out LSB first. Leaving TAP_SH_DR after fewer than 32 bits leaves a later full read unaffected.
- R5: Opcodes 00101, 00110, 00111, 01010, 11111, undefined opcodes and grant-range holes such as 11011 select a 1-bit bypass register. It captures 0 and delays TDI by one bit.
- R6: Opcodes 00010, 00011 and 00100 select boundary scan. `bsr_capture`, `bsr_shift` and `bsr_update` are high in TAP_CAP_DR, TAP_SH_DR and TAP_UPD_DR respectively, and in TAP_SH_DR the pin TDO carries `bsr_so`.
- R7: While opcode 00100 is active, `bsr_extest` and `func_reset_req` are 1. Under 00010 and 00011 both are 0.
- R8: Grant opcodes map onto `aux_sel` bits as follows: 10000→bit0, 10001→bit1 (core 0), 10110→bit2, 10111→bit3, 11000→bit4, 11001→bit5 (core 1). While a grant is held, `aux_tms` follows TMS, the selected `aux_tdi` bit follows TDI, the other `aux_tdi` bits are 1, `tdo_oe` is 1, and TDO equals the selected `aux_tdo` bit.
- R9: Lockstep opcode 11010 sets `aux_sel` bits 1 and 5 together and forwards TDI to both. TDO comes from `aux_tdo` bit 5.
- R10: A grant persists through later IR scans. It is released only by TAP_RESET or by `en` going low.
- R11: The registered TDO changes on the falling edge of TCK. It is driven (`tdo_oe`=1) only in TAP_SH_IR and TAP_SH_DR when no grant is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| en | input | 1 | Controller enable; low forces reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| tdo | output | 1 | Test data out |
| tdo_oe | output | 1 | Output enable for TDO |
| aux_sel | output | 6 | One select per auxiliary TAP |
| aux_tms | output | 1 | TMS forwarded to the auxiliaries (1 when no grant) |
| aux_tdi | output | 6 | TDI forwarded to each auxiliary (1 when unselected) |
| aux_tdo | input | 6 | TDO of each auxiliary |
| bsr_so | input | 1 | Serial output of the boundary-scan chain |
| bsr_capture | output | 1 | Boundary-scan capture strobe |
| bsr_shift | output | 1 | Boundary-scan shift strobe |
| bsr_update | output | 1 | Boundary-scan update strobe |
| bsr_extest | output | 1 | Drive preloaded values onto pins |
| func_reset_req | output | 1 | Functional reset request during external test |

## Verification
The hardest cases to reach are the ones that depend on timing within a scan rather than on the loaded opcode.

- **Opcode activation point.** The opcode must not take effect before TAP_UPD_IR. The bench shifts the external-test opcode, parks the machine in TAP_PAU_IR, and confirms there that the reset request is still low. It then walks through TAP_EX2_IR and TAP_UPD_IR to see the request rise.
- **Falling-edge TDO.** The bench steps TCK by hand in the middle of a bypass shift. It samples TDO after the rising edge and again after the falling edge.
- **Grant persistence.** An ordinary IR scan is run while a grant is held, and the grant must survive it.
- **Enable drop.** The enable is dropped during lockstep ownership, and the grant must be released.

// File: rtl/tsh_pkg.sv
`timescale 1ns/1ps
package tsh_pkg;
    localparam int IR_W  = 5;
    localparam int N_AUX = 6;
    localparam int CORE0 = 1;
    localparam int CORE1 = 5;

    localparam logic [IR_W-1:0] OP_IDCODE   = 5'b00001;
    localparam logic [IR_W-1:0] OP_SAMPLE_P = 5'b00010;
    localparam logic [IR_W-1:0] OP_SAMPLE   = 5'b00011;
    localparam logic [IR_W-1:0] OP_EXTEST   = 5'b00100;
    localparam logic [IR_W-1:0] IR_CAPTURE  = 5'b00001;
    localparam logic [N_AUX-1:0] LOCK_MASK  = N_AUX'((1 << CORE0) | (1 << CORE1));

    typedef enum logic [3:0] {
        TAP_RESET, TAP_IDLE, TAP_SEL_DR, TAP_CAP_DR, TAP_SH_DR, TAP_EX1_DR,
        TAP_PAU_DR, TAP_EX2_DR, TAP_UPD_DR, TAP_SEL_IR, TAP_CAP_IR, TAP_SH_IR,
        TAP_EX1_IR, TAP_PAU_IR, TAP_EX2_IR, TAP_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {DR_BYPASS, DR_IDCODE, DR_BSR} dr_sel_e;

    function automatic logic [N_AUX-1:0] grant_of(input logic [IR_W-1:0] op);
        case (op)
            5'b10000: grant_of = N_AUX'(1 << 0);
            5'b10001: grant_of = N_AUX'(1 << CORE0);
            5'b10110: grant_of = N_AUX'(1 << 2);
            5'b10111: grant_of = N_AUX'(1 << 3);
            5'b11000: grant_of = N_AUX'(1 << 4);
            5'b11001: grant_of = N_AUX'(1 << CORE1);
            5'b11010: grant_of = LOCK_MASK;
            default:  grant_of = '0;
        endcase
    endfunction
endpackage

// File: rtl/tsh_fsm.sv
`timescale 1ns/1ps
module tsh_fsm
    import tsh_pkg::*;
(
    input  logic       tck,
    input  logic       en,
    input  logic       tms,
    output tap_state_e state
);
    tap_state_e nxt;

    always_ff @(posedge tck or negedge en) begin
        if (!en) state <= TAP_RESET;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TAP_RESET:  nxt = tms ? TAP_RESET  : TAP_IDLE;
            TAP_IDLE:   nxt = tms ? TAP_SEL_DR : TAP_IDLE;
            TAP_SEL_DR: nxt = tms ? TAP_SEL_IR : TAP_CAP_DR;
            TAP_CAP_DR: nxt = tms ? TAP_EX1_DR : TAP_SH_DR;
            TAP_SH_DR:  nxt = tms ? TAP_EX1_DR : TAP_SH_DR;
            TAP_EX1_DR: nxt = tms ? TAP_UPD_DR : TAP_PAU_DR;
            TAP_PAU_DR: nxt = tms ? TAP_EX2_DR : TAP_PAU_DR;
            TAP_EX2_DR: nxt = tms ? TAP_UPD_DR : TAP_SH_DR;
            TAP_UPD_DR: nxt = tms ? TAP_SEL_DR : TAP_IDLE;
            TAP_SEL_IR: nxt = tms ? TAP_RESET  : TAP_CAP_IR;
            TAP_CAP_IR: nxt = tms ? TAP_EX1_IR : TAP_SH_IR;
            TAP_SH_IR:  nxt = tms ? TAP_EX1_IR : TAP_SH_IR;
            TAP_EX1_IR: nxt = tms ? TAP_UPD_IR : TAP_PAU_IR;
            TAP_PAU_IR: nxt = tms ? TAP_EX2_IR : TAP_PAU_IR;
            TAP_EX2_IR: nxt = tms ? TAP_UPD_IR : TAP_SH_IR;
            TAP_UPD_IR: nxt = tms ? TAP_SEL_DR : TAP_IDLE;
        endcase
    end

    // R2: with TMS high the reset state is never left
    p_reset_sticky_r2: assert property (@(posedge tck) disable iff (!en)
        (state == TAP_RESET && tms) |=> state == TAP_RESET);
endmodule

// File: rtl/tsh_ir.sv
`timescale 1ns/1ps
module tsh_ir
    import tsh_pkg::*;
(
    input  logic             tck,
    input  logic             en,
    input  logic             tdi,
    input  tap_state_e       state,
    output logic             ir_so,
    output dr_sel_e          dr_sel,
    output logic             extest,
    output logic [N_AUX-1:0] grant
);
    logic [IR_W-1:0] sh;
    logic [IR_W-1:0] active;

    always_ff @(posedge tck or negedge en) begin
        if (!en) begin
            sh     <= IR_CAPTURE;
            active <= OP_IDCODE;
            grant  <= '0;
        end else if (state == TAP_RESET) begin
            active <= OP_IDCODE;
            grant  <= '0;
        end else if (state == TAP_CAP_IR) begin
            sh <= IR_CAPTURE;
        end else if (state == TAP_SH_IR) begin
            sh <= {tdi, sh[IR_W-1:1]};
        end else if (state == TAP_UPD_IR && grant == '0) begin
            active <= sh;
            grant  <= grant_of(sh);
        end
    end

    assign ir_so  = sh[0];
    assign extest = (active == OP_EXTEST);

    always_comb begin
        case (active)
            OP_IDCODE:                           dr_sel = DR_IDCODE;
            OP_SAMPLE_P, OP_SAMPLE, OP_EXTEST:   dr_sel = DR_BSR;
            default:                             dr_sel = DR_BYPASS;
        endcase
    end

    // R3: the active opcode moves only on leaving update or in reset
    p_ir_hold_r3: assert property (@(posedge tck) disable iff (!en)
        (state != TAP_UPD_IR && state != TAP_RESET) |=> $stable(active));
    // R8: a grant appears only after the update state
    p_grant_at_update_r8: assert property (@(posedge tck) disable iff (!en)
        $rose(|grant) |-> $past(state) == TAP_UPD_IR);
    // R9: two selects at once only as the core lockstep pair
    p_lockstep_pair_r9: assert property (@(posedge tck) disable iff (!en)
        ($countones(grant) > 1) |-> grant == LOCK_MASK);
    // R10: reset releases ownership
    p_release_r10: assert property (@(posedge tck) disable iff (!en)
        (state == TAP_RESET) |=> grant == '0);
endmodule

// File: rtl/tsh_dr.sv
`timescale 1ns/1ps
module tsh_dr
    import tsh_pkg::*;
#(
    parameter int               ID_W     = 32,
    parameter logic [ID_W-1:0]  ID_VALUE = 32'h0BE4_701D
) (
    input  logic       tck,
    input  logic       en,
    input  logic       tdi,
    input  tap_state_e state,
    input  dr_sel_e    dr_sel,
    output logic       dr_so
);
    logic [ID_W-1:0] id_sh;
    logic            byp;

    always_ff @(posedge tck or negedge en) begin
        if (!en) begin
            id_sh <= ID_VALUE;
            byp   <= 1'b0;
        end else if (state == TAP_CAP_DR) begin
            id_sh <= ID_VALUE;
            byp   <= 1'b0;
        end else if (state == TAP_SH_DR) begin
            if (dr_sel == DR_IDCODE) id_sh <= {tdi, id_sh[ID_W-1:1]};
            if (dr_sel == DR_BYPASS) byp   <= tdi;
        end
    end

    assign dr_so = (dr_sel == DR_IDCODE) ? id_sh[0] : byp;

    // R4: after an identification capture the first bit out is 1
    p_id_lsb_r4: assert property (@(posedge tck) disable iff (!en)
        (state == TAP_CAP_DR && dr_sel == DR_IDCODE) |=> id_sh[0]);
    // R5: bypass capture yields 0
    p_byp_cap_r5: assert property (@(posedge tck) disable iff (!en)
        (state == TAP_CAP_DR) |=> !byp);
endmodule

// File: rtl/tsh_tap_share.sv
`timescale 1ns/1ps
module tsh_tap_share
    import tsh_pkg::*;
#(
    parameter logic [31:0] ID_VALUE = 32'h0BE4_701D
) (
    input  logic             tck,
    input  logic             en,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    output logic             tdo_oe,
    output logic [N_AUX-1:0] aux_sel,
    output logic             aux_tms,
    output logic [N_AUX-1:0] aux_tdi,
    input  logic [N_AUX-1:0] aux_tdo,
    input  logic             bsr_so,
    output logic             bsr_capture,
    output logic             bsr_shift,
    output logic             bsr_update,
    output logic             bsr_extest,
    output logic             func_reset_req
);
    tap_state_e       state;
    dr_sel_e          dr_sel;
    logic             ir_so, dr_so, extest, owned, lockstep, bsr_on;
    logic             tdo_r, oe_r, aux_pick;
    logic [N_AUX-1:0] grant;

    tsh_fsm i_fsm (.tck(tck), .en(en), .tms(tms), .state(state));

    tsh_ir i_ir (.tck(tck), .en(en), .tdi(tdi), .state(state), .ir_so(ir_so),
                 .dr_sel(dr_sel), .extest(extest), .grant(grant));

    tsh_dr #(.ID_W(32), .ID_VALUE(ID_VALUE)) i_dr (
        .tck(tck), .en(en), .tdi(tdi), .state(state), .dr_sel(dr_sel), .dr_so(dr_so));

    always_ff @(negedge tck or negedge en) begin
        if (!en) begin
            tdo_r <= 1'b0;
            oe_r  <= 1'b0;
        end else begin
            oe_r <= (state == TAP_SH_IR) || (state == TAP_SH_DR);
            if (state == TAP_SH_IR)    tdo_r <= ir_so;
            else if (dr_sel == DR_BSR) tdo_r <= bsr_so;
            else                       tdo_r <= dr_so;
        end
    end

    assign owned    = |grant;
    assign lockstep = (grant == LOCK_MASK);
    assign aux_pick = lockstep ? aux_tdo[CORE1] : |(aux_tdo & grant);
    assign aux_sel  = grant;
    assign aux_tms  = owned ? tms : 1'b1;

    for (genvar g = 0; g < N_AUX; g++) begin : g_fwd
        assign aux_tdi[g] = grant[g] ? tdi : 1'b1;
    end

    assign tdo    = owned ? aux_pick : tdo_r;
    assign tdo_oe = owned | oe_r;

    assign bsr_on         = (dr_sel == DR_BSR) && !owned;
    assign bsr_capture    = bsr_on && (state == TAP_CAP_DR);
    assign bsr_shift      = bsr_on && (state == TAP_SH_DR);
    assign bsr_update     = bsr_on && (state == TAP_UPD_DR);
    assign bsr_extest     = extest && !owned;
    assign func_reset_req = extest && !owned;

    // R6: at most one boundary-scan strobe per cycle
    p_strobe_excl_r6: assert property (@(posedge tck) disable iff (!en)
        $onehot0({bsr_capture, bsr_shift, bsr_update}));
    // R7: reset request only comes from the external-test path
    p_rst_req_r7: assert property (@(posedge tck) disable iff (!en)
        func_reset_req |-> (bsr_extest && aux_sel == '0));
endmodule

// File: tb/test_tsh_tap_share.sv
`timescale 1ns/1ps
module test_tsh_tap_share;
    localparam logic [31:0] ID = 32'h0BE4_701D;

    logic       tck = 1'b0, en = 1'b0, tms = 1'b1, tdi = 1'b0, bsr_so = 1'b0;
    logic [5:0] aux_tdo = '0;
    logic       tdo, tdo_oe, aux_tms, bsr_capture, bsr_shift, bsr_update, bsr_extest, func_reset_req;
    logic [5:0] aux_sel, aux_tdi;
    int         n_chk = 0, n_fail = 0;
    bit         done = 0;

    tsh_tap_share #(.ID_VALUE(ID)) i_tsh_tap_share (
        .tck(tck), .en(en), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
        .aux_sel(aux_sel), .aux_tms(aux_tms), .aux_tdi(aux_tdi), .aux_tdo(aux_tdo),
        .bsr_so(bsr_so), .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
        .bsr_update(bsr_update), .bsr_extest(bsr_extest), .func_reset_req(func_reset_req));

    always #4 tck = ~tck;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clk(input logic m, input logic d);
        tms = m; tdi = d;
        @(posedge tck); @(negedge tck); #1;
    endtask

    task automatic tap_reset();
        for (int i = 0; i < 5; i++) clk(1, 0);
        clk(0, 0);
    endtask

    task automatic load_ir(input logic [4:0] op, output logic [4:0] cap);
        clk(1, 0); clk(1, 0); clk(0, 0); clk(0, 0);
        for (int i = 0; i < 5; i++) begin cap[i] = tdo; clk(i == 4, op[i]); end
        clk(1, 0); clk(0, 0);
    endtask

    task automatic dr_scan(input int n, input logic [31:0] din, output logic [31:0] dout);
        dout = '0;
        clk(1, 0); clk(0, 0); clk(0, 0);
        for (int i = 0; i < n; i++) begin dout[i] = tdo; clk(i == n - 1, din[i]); end
        clk(1, 0); clk(0, 0);
    endtask

    function automatic logic [4:0] grant_op(input int k);
        case (k)
            0: return 5'b10000; 1: return 5'b10001; 2: return 5'b10110;
            3: return 5'b10111; 4: return 5'b11000; default: return 5'b11001;
        endcase
    endfunction

    task automatic t_enable();
        logic [31:0] d;
        for (int i = 0; i < 6; i++) clk(i[0], 0);
        check(tdo_oe == 0 && aux_sel == 0 && func_reset_req == 0, "R1 held reset outputs",
              {tdo_oe, aux_sel, func_reset_req}, 0);
        en = 1; clk(0, 0);
        dr_scan(32, 0, d);
        check(d == ID, "R1 idcode after enable", d, ID);
    endtask

    task automatic t_ir_activation();
        logic [4:0] cap;
        check(tdo_oe == 0, "R11 tdo off in idle", tdo_oe, 0);
        clk(1, 0); clk(1, 0); clk(0, 0); clk(0, 0);
        check(tdo_oe == 1, "R11 tdo on in shift-ir", tdo_oe, 1);
        for (int i = 0; i < 5; i++) begin cap[i] = tdo; clk(i == 4, OP_EXT[i]); end
        check(cap == 5'b00001, "R3 ir capture", cap, 5'b00001);
        clk(0, 0);
        check(func_reset_req == 0, "R3 not active in pause-ir", func_reset_req, 0);
        clk(1, 0); clk(1, 0); clk(0, 0);
        check(func_reset_req == 1 && bsr_extest == 1, "R7 extest active",
              {bsr_extest, func_reset_req}, 2'b11);
    endtask
    localparam logic [4:0] OP_EXT = 5'b00100;

    task automatic t_bsr(input logic [4:0] op);
        logic [4:0] cap;
        load_ir(op, cap);
        check(func_reset_req == 0 && bsr_extest == 0, "R7 sample no reset", func_reset_req, 0);
        clk(1, 0); clk(0, 0);
        check(bsr_capture == 1 && bsr_shift == 0, "R6 capture strobe", {bsr_capture, bsr_shift}, 2'b10);
        bsr_so = 1; clk(0, 0);
        check(bsr_shift == 1 && tdo == 1, "R6 shift strobe and tdo", {bsr_shift, tdo}, 2'b11);
        bsr_so = 0; clk(1, 0);
        check(bsr_shift == 0, "R6 shift ends", bsr_shift, 0);
        clk(1, 0);
        check(bsr_update == 1, "R6 update strobe", bsr_update, 1);
        clk(0, 0);
    endtask

    task automatic t_bypass(input logic [4:0] op);
        logic [4:0] cap;
        logic [7:0] din, dout, exp;
        din = 8'b1011_0011;
        load_ir(op, cap);
        clk(1, 0); clk(0, 0); clk(0, 0);
        for (int i = 0; i < 8; i++) begin dout[i] = tdo; clk(i == 7, din[i]); end
        clk(1, 0); clk(0, 0);
        exp = {din[6:0], 1'b0};
        check(dout == exp, "R5 bypass delay", dout, exp);
    endtask

    task automatic t_fall_edge();
        logic [4:0] cap;
        load_ir(5'b00110, cap);
        clk(1, 0); clk(0, 0); clk(0, 0);
        check(tdo == 0, "R5 bypass captures 0", tdo, 0);
        tms = 0; tdi = 1;
        @(posedge tck); #1;
        check(tdo == 0, "R11 no change at rising edge", tdo, 0);
        @(negedge tck); #1;
        check(tdo == 1, "R11 change at falling edge", tdo, 1);
        clk(1, 0); clk(1, 0); clk(0, 0);
    endtask

    task automatic t_partial();
        logic [4:0]  cap;
        logic [31:0] d;
        load_ir(5'b00001, cap);
        dr_scan(8, 32'hFF, d);
        check(d[7:0] == ID[7:0], "R4 partial read", d[7:0], ID[7:0]);
        dr_scan(32, 0, d);
        check(d == ID, "R4 full read after partial", d, ID);
    endtask

    task automatic t_grants();
        logic [4:0]  cap;
        logic [5:0]  m;
        logic [31:0] d;
        for (int k = 0; k < 6; k++) begin
            m = 6'(1 << k);
            load_ir(grant_op(k), cap);
            check(aux_sel == m && aux_tms == 0, "R8 select and tms", aux_sel, m);
            tdi = 1; #1;
            check(aux_tdi == 6'h3F, "R8 tdi high", aux_tdi, 6'h3F);
            tdi = 0; #1;
            check(aux_tdi == ~m, "R8 tdi low forwarded", aux_tdi, ~m);
            aux_tdo = m; #1;
            check(tdo == 1 && tdo_oe == 1, "R8 tdo from aux", tdo, 1);
            aux_tdo = ~m; #1;
            check(tdo == 0, "R8 tdo from aux low", tdo, 0);
            aux_tdo = 0;
            if (k == 2) begin
                load_ir(5'b00001, cap);
                check(aux_sel == m, "R10 grant survives ir scan", aux_sel, m);
            end
            tap_reset();
            check(aux_sel == 0 && aux_tms == 1, "R2 release on reset", aux_sel, 0);
        end
        dr_scan(32, 0, d);
        check(d == ID, "R2 idcode after reset", d, ID);
    endtask

    task automatic t_lockstep();
        logic [4:0] cap;
        load_ir(5'b11010, cap);
        check(aux_sel == 6'b100010, "R9 lockstep selects", aux_sel, 6'b100010);
        tdi = 0; #1;
        check(aux_tdi == 6'b011101, "R9 tdi to both cores", aux_tdi, 6'b011101);
        aux_tdo = 6'b100000; #1;
        check(tdo == 1, "R9 tdo from core1", tdo, 1);
        aux_tdo = 6'b000010; #1;
        check(tdo == 0, "R9 core0 tdo ignored", tdo, 0);
        aux_tdo = 0;
        en = 0; #1;
        check(aux_sel == 0, "R10 enable drop releases", aux_sel, 0);
        clk(1, 0); en = 1; clk(0, 0);
    endtask

    task automatic t_reset_ir();
        logic [4:0]  cap;
        logic [31:0] d;
        load_ir(5'b00111, cap);
        tap_reset();
        dr_scan(32, 0, d);
        check(d == ID, "R2 ir back to idcode", d, ID);
    endtask

    initial begin
        @(negedge tck); #1;
        t_enable();
        t_ir_activation();
        tap_reset();
        t_bsr(5'b00010);
        t_bsr(5'b00011);
        t_bypass(5'b00110);
        t_bypass(5'b11011);
        t_bypass(5'b11111);
        t_bypass(5'b01010);
        t_fall_edge();
        t_partial();
        t_grants();
        t_lockstep();
        t_reset_ir();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule